// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Code Generation

This block sits behind a page-table walker. Once a walk has finished, it receives the merged permission attributes of the leaf entry: the user-accessible flag, the writable flag, the no-execute flag and the 4-bit protection key. It also receives the kind of access (read, write or instruction fetch), whether the access comes from user or supervisor privilege, a set of paging control bits, two key-rights words and the virtual address. From these it builds the read/write/execute mask that the access may use, narrows that mask by the protection-key rights, and decides whether the access is allowed.

When the access is refused, or when the walker has already reported a missing or malformed entry, the block gives a page-fault verdict with a packed error code. In long mode it also checks that the virtual address is in canonical form. A non-canonical address gives a general-protection verdict, which replaces any page-fault outcome. The verdict, error code and mask are registered and come out one cycle after the input strobe, marked by a single-cycle valid pulse.

Top module: `pgperm_check`

## Requirements
- R1: While reset is high and after it, out_valid is 0 and out_fault, out_code and out_prot are 0. Each cycle with in_valid high gives out_valid high on the next cycle only. The other outputs are loaded in that same cycle and hold their values until the next strobe.
- R2: When mode_long is 1, the address bits from bit 47 upward (bit 56 upward when mode_lvl5 is 1) must be all zeros or all ones. Otherwise out_fault is 2 (general protection), out_code is 0 and out_prot is 0, whatever the other inputs are. When mode_long is 0, no such check is made.
- R3: in_walk encodes 0 = walk completed, 1 = entry not present, 2 = reserved bits set. Codes 1 and 2 give out_fault 1 (page fault) and out_prot 0, and take priority over every permission check. Code 1 leaves the present bit (bit 0) of the error code clear. Code 2 sets the reserved bit (bit 3) and leaves bit 0 clear.
- R4: A user access (in_user 1) to an entry with pte_user 0 gives a page fault with the present bit set and out_prot 0.
- R5: Read (out_prot bit 0) is granted except for a supervisor access with mode_sap set to an entry with pte_user 1.
- R6: Write (out_prot bit 1) requires read to be granted, and also requires either pte_wr set, or a supervisor access with mode_wp clear.
- R7: Execute (out_prot bit 2) requires pte_nx clear, and also requires a user access, or mode_sep clear, or pte_user 0.
- R8: The key-rights word is ukey_rights for a user entry when mode_ukey is 1, and skey_rights for a supervisor entry when mode_skey is 1. In all other cases the word is zero. For key k, bit 2k is access-disable and bit 2k+1 is write-disable.
- R9: Access-disable removes read and write. Write-disable removes write only for user accesses or when mode_wp is 1. Key rights never remove execute and never refuse a fetch.
- R10: A key-rights refusal gives a page fault with the key bit (bit 5) and the present bit (bit 0) set. It takes priority over a refusal by the entry's own permissions.
- R11: in_acc encodes 0 = read, 1 = write, 2 = fetch. An access whose type is missing from the mask, with no earlier fault, gives a page fault with the present bit set. An allowed access gives out_fault 0 and out_code 0. out_prot shows the mask after key rights whenever R2, R3 and R4 do not apply.
- R12: Every page-fault code adds the user bit (bit 2) for user accesses and the write bit (bit 1) for writes. It adds the fetch bit (bit 4) for fetches only when mode_nxe or mode_sep is 1. Bits above 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| in_user | input | 1 | 1 for a user-privilege access |
| in_walk | input | 2 | Walker outcome: 0 ok, 1 not present, 2 reserved bits |
| pte_user | input | 1 | Merged user-accessible flag of the entry |
| pte_wr | input | 1 | Merged writable flag |
| pte_nx | input | 1 | Merged no-execute flag |
| pte_key | input | KEY_W | Protection key of the entry |
| vaddr | input | ADDR_W | Virtual address of the access |
| mode_wp | input | 1 | Supervisor write protection enforced |
| mode_sap | input | 1 | Supervisor access to user pages prevented |
| mode_sep | input | 1 | Supervisor execution of user pages prevented |
| mode_nxe | input | 1 | No-execute enabled |
| mode_ukey | input | 1 | User protection keys enabled |
| mode_skey | input | 1 | Supervisor protection keys enabled |
| mode_long | input | 1 | Long mode active |
| mode_lvl5 | input | 1 | Five-level paging active |
| ukey_rights | input | RIGHTS_W | Key-rights word for user entries |
| skey_rights | input | RIGHTS_W | Key-rights word for supervisor entries |
| out_valid | output | 1 | Result pulse |
| out_fault | output | 2 | 0 none, 1 page fault, 2 general protection |
| out_code | output | ERR_W | Page-fault error code |
| out_prot | output | 3 | Granted mask: bit 0 read, bit 1 write, bit 2 execute |

## Verification
A single access can be refused by a key's rights and by the entry's own permission bits at the same time. The bench provokes this with a user write to a read-only page whose key has write-disable set. The result counts as correct only if the key bit is present in the code, so the key refusal was reported. A second overlap is a non-canonical long-mode address that arrives with a walker reserved-bit fault. Here the verdict must be general protection with a zero code and an empty mask.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_GP   = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        WALK_OK     = 2'd0,
        WALK_ABSENT = 2'd1,
        WALK_RSVD   = 2'd2
    } walk_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rwx_t;

    localparam int CODE_BITS = 6;
    localparam int EB_P    = 0;
    localparam int EB_W    = 1;
    localparam int EB_U    = 2;
    localparam int EB_RSVD = 3;
    localparam int EB_ID   = 4;
    localparam int EB_PK   = 5;

    typedef struct packed {
        flt_e                  kind;
        logic [CODE_BITS-1:0]  code;
        rwx_t                  prot;
    } verdict_t;

    function automatic logic acc_allowed(rwx_t m, acc_e a);
        case (a)
            ACC_READ:  return m.r;
            ACC_WRITE: return m.w;
            ACC_FETCH: return m.x;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [CODE_BITS-1:0] ctx_flags(logic usr, acc_e a,
                                                       logic nxe, logic sep);
        logic [CODE_BITS-1:0] f;
        f        = '0;
        f[EB_U]  = usr;
        f[EB_W]  = (a == ACC_WRITE);
        f[EB_ID] = (a == ACC_FETCH) && (nxe || sep);
        return f;
    endfunction

endpackage

// File: rtl/pgperm_rights.sv
module pgperm_rights
    import pgperm_pkg::*;
(
    input  logic user_mode,
    input  logic pg_user,
    input  logic pg_wr,
    input  logic pg_nx,
    input  logic wp,
    input  logic sap,
    input  logic sep,
    output rwx_t base
);
    always_comb begin
        base.r = !(!user_mode && sap && pg_user);
        base.w = base.r && (pg_wr || (!user_mode && !wp));
        base.x = !pg_nx && (user_mode || !sep || !pg_user);
    end
endmodule

// File: rtl/pgperm_keys.sv
module pgperm_keys
    import pgperm_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                user_mode,
    input  logic                pg_user,
    input  logic [KEY_W-1:0]    key,
    input  logic                wp,
    input  logic                ukey_en,
    input  logic                skey_en,
    input  logic [RIGHTS_W-1:0] urights,
    input  logic [RIGHTS_W-1:0] srights,
    output rwx_t                kmask
);
    logic [RIGHTS_W-1:0] word;
    logic                ad, wd;

    always_comb begin
        if (pg_user) word = ukey_en ? urights : '0;
        else         word = skey_en ? srights : '0;
        ad = word[{key, 1'b0}];
        wd = word[{key, 1'b1}];
        kmask.r = !ad;
        kmask.w = !ad && !(wd && (user_mode || wp));
        kmask.x = 1'b1;
    end
endmodule

// File: rtl/pgperm_canon.sv
module pgperm_canon #(
    parameter int ADDR_W = 64,
    parameter int SH4    = 47,
    parameter int SH5    = 56
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              long_en,
    input  logic              lvl5,
    output logic              ok
);
    logic [ADDR_W-1-SH4:0] hi4;
    logic [ADDR_W-1-SH5:0] hi5;
    logic                  ok4, ok5;

    always_comb begin
        hi4 = addr[ADDR_W-1:SH4];
        hi5 = addr[ADDR_W-1:SH5];
        ok4 = (&hi4) || !(|hi4);
        ok5 = (&hi5) || !(|hi5);
        ok  = !long_en || (lvl5 ? ok5 : ok4);
    end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int KEY_W  = 4,
    parameter int ERR_W  = 16,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_acc,
    input  logic                in_user,
    input  logic [1:0]          in_walk,
    input  logic                pte_user,
    input  logic                pte_wr,
    input  logic                pte_nx,
    input  logic [KEY_W-1:0]    pte_key,
    input  logic [ADDR_W-1:0]   vaddr,
    input  logic                mode_wp,
    input  logic                mode_sap,
    input  logic                mode_sep,
    input  logic                mode_nxe,
    input  logic                mode_ukey,
    input  logic                mode_skey,
    input  logic                mode_long,
    input  logic                mode_lvl5,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic                out_valid,
    output logic [1:0]          out_fault,
    output logic [ERR_W-1:0]    out_code,
    output logic [2:0]          out_prot
);
    acc_e     acc;
    walk_e    walk;
    rwx_t     base, kmask, fin;
    logic     canon_ok;
    logic     key_deny, perm_deny, usr_sup;
    logic [CODE_BITS-1:0] flags;
    verdict_t v;

    assign acc  = acc_e'(in_acc);
    assign walk = walk_e'(in_walk);

    pgperm_rights u_rights (
        .user_mode (in_user),
        .pg_user   (pte_user),
        .pg_wr     (pte_wr),
        .pg_nx     (pte_nx),
        .wp        (mode_wp),
        .sap       (mode_sap),
        .sep       (mode_sep),
        .base      (base)
    );

    pgperm_keys #(.KEY_W(KEY_W)) u_keys (
        .user_mode (in_user),
        .pg_user   (pte_user),
        .key       (pte_key),
        .wp        (mode_wp),
        .ukey_en   (mode_ukey),
        .skey_en   (mode_skey),
        .urights   (ukey_rights),
        .srights   (skey_rights),
        .kmask     (kmask)
    );

    pgperm_canon #(.ADDR_W(ADDR_W)) u_canon (
        .addr    (vaddr),
        .long_en (mode_long),
        .lvl5    (mode_lvl5),
        .ok      (canon_ok)
    );

    always_comb begin
        fin       = base & kmask;
        flags     = ctx_flags(in_user, acc, mode_nxe, mode_sep);
        usr_sup   = in_user && !pte_user;
        key_deny  = (acc != ACC_FETCH) && !acc_allowed(kmask, acc);
        perm_deny = !acc_allowed(base, acc);
        v.kind    = FLT_NONE;
        v.code    = '0;
        v.prot    = fin;
        if (!canon_ok) begin
            v.kind = FLT_GP;
            v.prot = '0;
        end else if (walk == WALK_ABSENT) begin
            v.kind = FLT_PAGE;
            v.code = flags;
            v.prot = '0;
        end else if (walk == WALK_RSVD) begin
            v.kind = FLT_PAGE;
            v.code = flags;
            v.code[EB_RSVD] = 1'b1;
            v.prot = '0;
        end else if (usr_sup) begin
            v.kind = FLT_PAGE;
            v.code = flags;
            v.code[EB_P] = 1'b1;
            v.prot = '0;
        end else if (key_deny) begin
            v.kind = FLT_PAGE;
            v.code = flags;
            v.code[EB_P]  = 1'b1;
            v.code[EB_PK] = 1'b1;
        end else if (perm_deny) begin
            v.kind = FLT_PAGE;
            v.code = flags;
            v.code[EB_P] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fault <= '0;
            out_code  <= '0;
            out_prot  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_fault <= v.kind;
                out_code  <= ERR_W'(v.code);
                out_prot  <= v.prot;
            end
        end
    end
endmodule

// File: rtl/pgperm_sva.sv
module pgperm_sva #(
    parameter int ADDR_W = 64,
    parameter int KEY_W  = 4,
    parameter int ERR_W  = 16,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          in_acc,
    input logic                in_user,
    input logic [1:0]          in_walk,
    input logic                pte_user,
    input logic                mode_long,
    input logic                out_valid,
    input logic [1:0]          out_fault,
    input logic [ERR_W-1:0]    out_code
);
    p_pulse_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_quiet_without_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_gp_zero_code_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault == 2'd2) |-> (out_code == '0));

    p_rsvd_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_long && in_walk == 2'd2)
        |=> (out_fault == 2'd1 && out_code[3] && !out_code[0]));

    p_user_to_sup_page_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_long && in_walk == 2'd0 && in_user && !pte_user)
        |=> (out_fault == 2'd1 && out_code[0] && out_code[2]));

    p_fetch_no_key_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_acc == 2'd2) |=> !out_code[5]);

    p_key_has_present_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_code[5]) |-> (out_code[0] && out_fault == 2'd1));

    p_upper_code_zero_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code[ERR_W-1:6] == '0));
endmodule

bind pgperm_check pgperm_sva #(
    .ADDR_W (ADDR_W),
    .KEY_W  (KEY_W),
    .ERR_W  (ERR_W)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_acc    (in_acc),
    .in_user   (in_user),
    .in_walk   (in_walk),
    .pte_user  (pte_user),
    .mode_long (mode_long),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_code  (out_code)
);

// File: tb/test_pgperm_check.sv
module test_pgperm_check;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_acc;
    logic        in_user;
    logic [1:0]  in_walk;
    logic        pte_user, pte_wr, pte_nx;
    logic [3:0]  pte_key;
    logic [63:0] vaddr;
    logic        mode_wp, mode_sap, mode_sep, mode_nxe;
    logic        mode_ukey, mode_skey, mode_long, mode_lvl5;
    logic [31:0] ukey_rights, skey_rights;
    logic        out_valid;
    logic [1:0]  out_fault;
    logic [15:0] out_code;
    logic [2:0]  out_prot;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgperm_check i_pgperm_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
        .in_user(in_user), .in_walk(in_walk), .pte_user(pte_user),
        .pte_wr(pte_wr), .pte_nx(pte_nx), .pte_key(pte_key), .vaddr(vaddr),
        .mode_wp(mode_wp), .mode_sap(mode_sap), .mode_sep(mode_sep),
        .mode_nxe(mode_nxe), .mode_ukey(mode_ukey), .mode_skey(mode_skey),
        .mode_long(mode_long), .mode_lvl5(mode_lvl5),
        .ukey_rights(ukey_rights), .skey_rights(skey_rights),
        .out_valid(out_valid), .out_fault(out_fault), .out_code(out_code),
        .out_prot(out_prot)
    );

    task automatic defaults();
        in_acc = 2'd0; in_user = 0; in_walk = 2'd0;
        pte_user = 0; pte_wr = 1; pte_nx = 0; pte_key = 4'd0;
        vaddr = 64'h0000_0000_1234_5000;
        mode_wp = 0; mode_sap = 0; mode_sep = 0; mode_nxe = 0;
        mode_ukey = 0; mode_skey = 0; mode_long = 0; mode_lvl5 = 0;
        ukey_rights = '0; skey_rights = '0;
    endtask

    task automatic check(string tag, logic ev, logic [1:0] ef,
                         logic [15:0] ec, logic [2:0] ep);
        total++;
        if (out_valid !== ev || out_fault !== ef || out_code !== ec || out_prot !== ep) begin
            bad++;
            $display("FAIL %s: valid=%0b/%0b fault=%0d/%0d code=%0h/%0h prot=%0h/%0h",
                     tag, out_valid, ev, out_fault, ef, out_code, ec, out_prot, ep);
        end
    endtask

    // one strobe; outputs registered at the following edge, sampled at next negedge
    task automatic strobe_and_check(string tag, logic [1:0] ef,
                                    logic [15:0] ec, logic [2:0] ep);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check(tag, 1'b1, ef, ec, ep);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1; in_valid = 0; defaults();
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 2'd0, 16'h0, 3'h0);
        rst = 0;
        @(negedge clk);
        check("R1 idle after reset", 1'b0, 2'd0, 16'h0, 3'h0);
    endtask

    task automatic t_basic_rights();
        defaults();
        strobe_and_check("R5 R6 R7 supervisor read full rights", 2'd0, 16'h0, 3'h7);
        defaults(); in_user = 1; pte_user = 1; pte_wr = 0; in_acc = 2'd1;
        strobe_and_check("R6 R11 R12 user write read-only", 2'd1, 16'h7, 3'h5);
        defaults(); pte_wr = 0; in_acc = 2'd1;
        strobe_and_check("R6 supervisor write wp clear", 2'd0, 16'h0, 3'h7);
        defaults(); pte_wr = 0; in_acc = 2'd1; mode_wp = 1;
        strobe_and_check("R6 supervisor write wp set", 2'd1, 16'h3, 3'h5);
    endtask

    task automatic t_sup_prevention();
        defaults(); pte_user = 1; mode_sap = 1;
        strobe_and_check("R5 supervisor read user page prevented", 2'd1, 16'h1, 3'h4);
        defaults(); pte_user = 1; mode_sep = 1; in_acc = 2'd2;
        strobe_and_check("R7 R12 supervisor fetch user page prevented", 2'd1, 16'h11, 3'h3);
    endtask

    task automatic t_noexec();
        defaults(); in_user = 1; pte_user = 1; pte_nx = 1; mode_nxe = 1; in_acc = 2'd2;
        strobe_and_check("R7 R12 nx fetch with fetch flag", 2'd1, 16'h15, 3'h3);
        mode_nxe = 0;
        strobe_and_check("R12 nx fetch without fetch flag", 2'd1, 16'h5, 3'h3);
    endtask

    task automatic t_user_sup_page();
        defaults(); in_user = 1; pte_user = 0;
        strobe_and_check("R4 user read supervisor page", 2'd1, 16'h5, 3'h0);
    endtask

    task automatic t_keys();
        defaults(); in_user = 1; pte_user = 1; pte_key = 4'd3;
        ukey_rights = 32'h0000_0040; mode_ukey = 1;
        strobe_and_check("R8 R9 R10 access-disable on read", 2'd1, 16'h25, 3'h4);
        in_acc = 2'd2;
        strobe_and_check("R9 key never refuses fetch", 2'd0, 16'h0, 3'h4);
        in_acc = 2'd0; mode_ukey = 0;
        strobe_and_check("R8 user keys disabled", 2'd0, 16'h0, 3'h7);
        defaults(); in_user = 1; pte_user = 1; pte_key = 4'd5; in_acc = 2'd1;
        ukey_rights = 32'h0000_0800; mode_ukey = 1;
        strobe_and_check("R9 R10 write-disable user write", 2'd1, 16'h27, 3'h5);
        pte_wr = 0;
        strobe_and_check("R10 key refusal wins over read-only", 2'd1, 16'h27, 3'h5);
        defaults(); pte_key = 4'd2; in_acc = 2'd1; skey_rights = 32'h0000_0020; mode_skey = 1;
        strobe_and_check("R9 write-disable ignored supervisor wp clear", 2'd0, 16'h0, 3'h7);
        mode_wp = 1;
        strobe_and_check("R9 R10 write-disable supervisor wp set", 2'd1, 16'h23, 3'h5);
        defaults(); pte_key = 4'd1; ukey_rights = 32'h0000_0004; mode_ukey = 1; mode_skey = 1;
        strobe_and_check("R8 supervisor page uses supervisor word", 2'd0, 16'h0, 3'h7);
        defaults(); in_user = 1; pte_user = 1; pte_key = 4'd1;
        skey_rights = 32'h0000_0004; mode_skey = 1;
        strobe_and_check("R8 user page ignores supervisor word", 2'd0, 16'h0, 3'h7);
    endtask

    task automatic t_walker();
        defaults(); in_user = 1; pte_user = 1; in_acc = 2'd1; in_walk = 2'd1;
        strobe_and_check("R3 R12 not-present user write", 2'd1, 16'h6, 3'h0);
        defaults(); in_walk = 2'd2;
        strobe_and_check("R3 reserved-bit supervisor read", 2'd1, 16'h8, 3'h0);
    endtask

    task automatic t_canonical();
        defaults(); mode_long = 1; vaddr = 64'h0000_8000_0000_0000;
        strobe_and_check("R2 non-canonical four-level", 2'd2, 16'h0, 3'h0);
        vaddr = 64'hFFFF_8000_0000_0000;
        strobe_and_check("R2 canonical negative four-level", 2'd0, 16'h0, 3'h7);
        mode_lvl5 = 1; vaddr = 64'h0000_8000_0000_0000;
        strobe_and_check("R2 canonical five-level", 2'd0, 16'h0, 3'h7);
        vaddr = 64'h0100_0000_0000_0000;
        strobe_and_check("R2 non-canonical five-level", 2'd2, 16'h0, 3'h0);
        mode_long = 0;
        strobe_and_check("R2 no check outside long mode", 2'd0, 16'h0, 3'h7);
        mode_long = 1; mode_lvl5 = 0; vaddr = 64'h0000_8000_0000_0000; in_walk = 2'd2;
        strobe_and_check("R2 R3 general protection wins over walker", 2'd2, 16'h0, 3'h0);
    endtask

    task automatic t_back_to_back();
        defaults(); in_user = 1; pte_user = 0;
        in_valid = 1;
        @(negedge clk);
        defaults();
        @(negedge clk);
        in_valid = 0;
        total++;
        if (out_valid !== 1'b1 || out_fault !== 2'd0 || out_prot !== 3'h7) begin
            bad++;
            $display("FAIL R1 second of back-to-back: valid=%0b/1 fault=%0d/0 prot=%0h/7",
                     out_valid, out_fault, out_prot);
        end
        @(negedge clk);
        check("R1 outputs hold after pulse", 1'b0, 2'd0, 16'h0, 3'h7);
    endtask

    task automatic t_first_of_pair();
        defaults(); in_user = 1; pte_user = 0;
        in_valid = 1;
        @(negedge clk);
        check("R1 R4 first of back-to-back", 1'b1, 2'd1, 16'h5, 3'h0);
        in_valid = 0;
        @(negedge clk);
        check("R1 hold fault values", 1'b0, 2'd1, 16'h5, 3'h0);
    endtask

    initial begin
        in_valid = 0;
        t_reset();
        t_basic_rights();
        t_sup_prevention();
        t_noexec();
        t_user_sup_page();
        t_keys();
        t_walker();
        t_canonical();
        t_first_of_pair();
        t_back_to_back();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule